// File: doc/BRIEF.md
# Pixel Queue Serializer

This block sits between a parallel array of line-stepping operators and a video memory write port. Each line is started by a one-cycle command that carries the line's first point, its color and an axis-swap flag. The block sends that first point to memory with no end test, because every line covers at least one pixel. It then asks the operator array for a batch.

A batch holds NOPS computed points, and each point carries an end flag. The block writes the points one per accepted cycle, starting at operator 0 and counting up. It stops at the first point whose end flag is set. If no point in the batch is flagged, it asks for the next batch once the last operator's point has been accepted. After the flagged point it gives a one-cycle completion pulse and waits for the next line command.

Points arrive as (major, minor) pairs. The swap flag picks how they land on the x and y outputs. This lets one operator array serve lines that step along either screen axis.

Top module: `pixel_queue_serializer`

## Requirements
- R1: While reset is held and after it is released, pix_valid, batch_ready and line_done are all low.
- R2: A line_go seen while idle causes pix_valid in the next cycle. The first point of the line is the start point given with the command, whatever the batch flags hold.
- R3: batch_ready rises only after the start point or the last point of a batch has been accepted. A batch is taken in a cycle where batch_valid and batch_ready are both high.
- R4: The points of a batch are written in operator order 0, 1, ... NOPS-1. Operator i's major coordinate is batch_major[i*CW +: CW] and its minor coordinate is batch_minor[i*CW +: CW]. At most one point is written per clock, and only in a cycle where pix_valid and pix_ready are both high.
- R5: The point whose batch_end bit is set is the last point of the line. Points after it in the batch are never written. line_done is high for exactly one cycle, the cycle after that point is accepted. The block then stays idle: no pix_valid and no batch_ready until the next line_go.
- R6: When a batch has no end bit set, batch_ready is high again in the cycle after operator NOPS-1's point is accepted.
- R7: While pix_valid is high and pix_ready is low, pix_valid, pix_x, pix_y and pix_color stay unchanged into the next cycle.
- R8: With the swap flag 0, pix_x takes the major coordinate and pix_y takes the minor one. With the swap flag 1, pix_x takes the minor coordinate and pix_y takes the major one.
- R9: A line_go given while a line is in progress is ignored. The points, color and swap of the current line are unchanged.
- R10: Every point of a line carries the color given with that line's command.
- R11: pix_valid and batch_ready are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_go | input | 1 | One-cycle line command |
| go_major | input | CW | Start point, major coordinate |
| go_minor | input | CW | Start point, minor coordinate |
| go_color | input | COLW | Line color |
| go_swap | input | 1 | 1: the major axis is y |
| batch_valid | input | 1 | The operator array has a batch ready |
| batch_major | input | NOPS*CW | Major coordinates, operator i at bits i*CW |
| batch_minor | input | NOPS*CW | Minor coordinates, operator i at bits i*CW |
| batch_end | input | NOPS | End flag for each operator |
| batch_ready | output | 1 | Request for, and accept of, the next batch |
| pix_valid | output | 1 | Pixel write request |
| pix_ready | input | 1 | The memory port accepts the request |
| pix_x | output | CW | Pixel x coordinate |
| pix_y | output | CW | Pixel y coordinate |
| pix_color | output | COLW | Pixel color |
| line_done | output | 1 | One-cycle pulse after the final pixel |

## Verification
The assertions check the cycle-level rules on every clock. These are: held output during a stall, no overlap between a write request and a batch request, a batch request only after an accepted write, the index stepping by one, the completion pulse coming right after an accepted write, and an ignored command leaving the color alone. Only the bench scenarios can show that the right coordinates come out in the right order for both swap settings. The same goes for stopping exactly at the flagged operator across batch boundaries and under irregular ready and valid patterns, and for staying idle once the line is done.

// File: rtl/pq_pkg.sv
// Shared types for the pixel queue serializer.
package pq_pkg;
    // Sequencer states: idle, start point out, waiting on a batch, batch entries out.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_EMIT  = 2'd3
    } pq_state_t;
endpackage

// File: rtl/pq_batch_store.sv
// Holds one batch of operator results and presents the entry picked by sel.
// Assumes: load is asserted only when the previous batch has been used up.
module pq_batch_store #(
    parameter int NOPS  = 4,
    parameter int CW    = 12,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NOPS*CW-1:0]   in_major,
    input  logic [NOPS*CW-1:0]   in_minor,
    input  logic [NOPS-1:0]      in_end,
    input  logic [IDX_W-1:0]     sel,
    output logic [CW-1:0]        out_major,
    output logic [CW-1:0]        out_minor,
    output logic                 out_end
);
    logic [NOPS-1:0][CW-1:0] maj_q;
    logic [NOPS-1:0][CW-1:0] min_q;
    logic [NOPS-1:0]         end_q;

    // Capture the whole batch when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maj_q <= '0;
            min_q <= '0;
            end_q <= '0;
        end else if (load) begin
            maj_q <= in_major;
            min_q <= in_minor;
            end_q <= in_end;
        end
    end

    // Select the entry currently being sent.
    always_comb begin
        out_major = maj_q[sel];
        out_minor = min_q[sel];
        out_end   = end_q[sel];
    end
endmodule

// File: rtl/pq_axis_map.sv
// Maps a (major, minor) pair onto screen (x, y) according to the swap flag.
// Assumes: swap is constant for the whole line.
module pq_axis_map #(
    parameter int CW = 12
) (
    input  logic          swap,
    input  logic [CW-1:0] major,
    input  logic [CW-1:0] minor,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y
);
    // Route coordinates to the screen axes.
    always_comb begin
        if (swap) begin
            x = minor;
            y = major;
        end else begin
            x = major;
            y = minor;
        end
    end
endmodule

// File: rtl/pixel_queue_serializer.sv
// Turns a start point plus batches of parallel operator results into a
// stream of pixel writes, stopping at the first entry with its end flag set.
// Assumes: batch_* are stable while batch_valid is high; NOPS >= 2.
module pixel_queue_serializer #(
    parameter int NOPS = 4,
    parameter int CW   = 12,
    parameter int COLW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_go,
    input  logic [CW-1:0]       go_major,
    input  logic [CW-1:0]       go_minor,
    input  logic [COLW-1:0]     go_color,
    input  logic                go_swap,
    input  logic                batch_valid,
    input  logic [NOPS*CW-1:0]  batch_major,
    input  logic [NOPS*CW-1:0]  batch_minor,
    input  logic [NOPS-1:0]     batch_end,
    output logic                batch_ready,
    output logic                pix_valid,
    input  logic                pix_ready,
    output logic [CW-1:0]       pix_x,
    output logic [CW-1:0]       pix_y,
    output logic [COLW-1:0]     pix_color,
    output logic                line_done
);
    import pq_pkg::*;

    localparam int IDX_W = $clog2(NOPS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NOPS - 1);

    pq_state_t          st;
    logic [IDX_W-1:0]   idx;
    logic [CW-1:0]      start_maj, start_min;
    logic [COLW-1:0]    col_q;
    logic               swap_q;
    logic               done_q;
    logic [CW-1:0]      sel_major, sel_minor;
    logic               sel_end;
    logic [CW-1:0]      cur_major, cur_minor;
    logic               take_batch;
    logic               accept;

    assign pix_valid   = (st == ST_START) || (st == ST_EMIT);
    assign batch_ready = (st == ST_WAIT);
    assign take_batch  = batch_ready && batch_valid;
    assign accept      = pix_valid && pix_ready;
    assign pix_color   = col_q;
    assign line_done   = done_q;

    pq_batch_store #(.NOPS(NOPS), .CW(CW), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_batch),
        .in_major (batch_major),
        .in_minor (batch_minor),
        .in_end   (batch_end),
        .sel      (idx),
        .out_major(sel_major),
        .out_minor(sel_minor),
        .out_end  (sel_end)
    );

    // Pick the start point or the current batch entry.
    always_comb begin
        if (st == ST_START) begin
            cur_major = start_maj;
            cur_minor = start_min;
        end else begin
            cur_major = sel_major;
            cur_minor = sel_minor;
        end
    end

    pq_axis_map #(.CW(CW)) u_map (
        .swap (swap_q),
        .major(cur_major),
        .minor(cur_minor),
        .x    (pix_x),
        .y    (pix_y)
    );

    // Line sequencer: start point, batch fetch, ordered emission, end detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            idx       <= '0;
            start_maj <= '0;
            start_min <= '0;
            col_q     <= '0;
            swap_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (line_go) begin
                    start_maj <= go_major;
                    start_min <= go_minor;
                    col_q     <= go_color;
                    swap_q    <= go_swap;
                    st        <= ST_START;
                end
                ST_START: if (pix_ready) st <= ST_WAIT;
                ST_WAIT: if (batch_valid) begin
                    idx <= '0;
                    st  <= ST_EMIT;
                end
                ST_EMIT: if (pix_ready) begin
                    if (sel_end)              st  <= ST_IDLE;
                    else if (idx == LAST_IDX) st  <= ST_WAIT;
                    else                      idx <= idx + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse one cycle after the flagged entry is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= accept && (st == ST_EMIT) && sel_end;
    end

    // R2: a command taken while idle yields a write request next cycle.
    p_go_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_go && st == ST_IDLE) |=> pix_valid);

    // R3: a batch request only follows an accepted write.
    p_ready_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batch_ready) |-> $past(pix_valid && pix_ready));

    // R4: entries advance one operator at a time.
    p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st == ST_EMIT && !sel_end && idx != LAST_IDX) |=>
        (idx == $past(idx) + 1'b1));

    // R5: completion follows an accepted write and leaves the block quiet.
    p_done_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> ($past(pix_valid && pix_ready) && !pix_valid && !batch_ready));

    // R7: a stalled request holds its contents.
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=>
        (pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_color)));

    // R9: a command during a line leaves the line's color alone.
    p_busy_go_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_go && st != ST_IDLE) |=> $stable(pix_color));

    // R11: writing and fetching never overlap.
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && batch_ready));
endmodule

// File: tb/tb_pixel_queue_serializer.sv
`timescale 1ns/1ps
module tb_pixel_queue_serializer;
    localparam int NOPS = 4;
    localparam int CW   = 12;
    localparam int COLW = 8;

    typedef struct packed {
        logic        swap;
        logic [7:0]  col;
        logic [11:0] smaj;
        logic [11:0] smin;
        logic [11:0] step;
        logic [3:0]  nb;
        logic [3:0]  lastpos;
        logic [7:0]  rdy;
        logic [7:0]  bvm;
        logic        poke;
    } row_t;

    // swap, color, start major, start minor, minor step, batches, flagged op,
    // ready pattern, batch-valid pattern, send a stray command mid-line.
    localparam row_t TBL [6] = '{
        '{1'b0, 8'h3C, 12'd100,  12'd50,   12'd1,     4'd2, 4'd1, 8'hFF,        8'hFF,        1'b0},
        '{1'b1, 8'hA5, 12'd7,    12'd900,  12'd3,     4'd1, 4'd0, 8'hFF,        8'hFF,        1'b0},
        '{1'b0, 8'h11, 12'd4000, 12'hFF0,  12'd7,     4'd3, 4'd3, 8'b10110010,  8'b01010101,  1'b1},
        '{1'b1, 8'h5A, 12'd0,    12'd0,    12'd2,     4'd2, 4'd2, 8'b00010001,  8'hFF,        1'b1},
        '{1'b0, 8'hFF, 12'd2047, 12'd1,    12'hFFF,   4'd1, 4'd3, 8'b11101110,  8'b00000011,  1'b0},
        '{1'b1, 8'h00, 12'd300,  12'd300,  12'd0,     4'd4, 4'd2, 8'hFF,        8'b11110000,  1'b1}
    };

    logic                clk = 1'b0;
    logic                rst_n;
    logic                line_go;
    logic [CW-1:0]       go_major, go_minor;
    logic [COLW-1:0]     go_color;
    logic                go_swap;
    logic                batch_valid;
    logic [NOPS*CW-1:0]  batch_major, batch_minor;
    logic [NOPS-1:0]     batch_end;
    logic                batch_ready;
    logic                pix_valid;
    logic                pix_ready;
    logic [CW-1:0]       pix_x, pix_y;
    logic [COLW-1:0]     pix_color;
    logic                line_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pixel_queue_serializer #(.NOPS(NOPS), .CW(CW), .COLW(COLW)) dut (
        .clk(clk), .rst_n(rst_n), .line_go(line_go),
        .go_major(go_major), .go_minor(go_minor), .go_color(go_color), .go_swap(go_swap),
        .batch_valid(batch_valid), .batch_major(batch_major), .batch_minor(batch_minor),
        .batch_end(batch_end), .batch_ready(batch_ready),
        .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color), .line_done(line_done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive the batch with index bi of line r; entries past the flag hold junk points.
    task automatic drive_batch(input row_t r, input int bi);
        for (int i = 0; i < NOPS; i++) begin
            int n = bi * NOPS + i + 1;
            batch_major[i*CW +: CW] = r.smaj + CW'(n);
            batch_minor[i*CW +: CW] = r.smin + CW'(n) * r.step;
            batch_end[i] = (bi == int'(r.nb) - 1) && (i == int'(r.lastpos));
        end
    endtask

    task automatic run_row(input row_t r, input int ri);
        int total = 1 + (int'(r.nb) - 1) * NOPS + int'(r.lastpos) + 1;
        int k = 0;
        int bi = 0;
        int cyc = 0;
        logic hold_v = 1'b0;
        logic [CW-1:0] hx = '0, hy = '0;
        logic [COLW-1:0] hc = '0;
        @(negedge clk);
        go_major = r.smaj; go_minor = r.smin; go_color = r.col; go_swap = r.swap;
        line_go = 1'b1;
        @(negedge clk);
        line_go = 1'b0;
        while (k < total && cyc < 3000) begin
            pix_ready   = r.rdy[cyc % 8];
            batch_valid = (bi < int'(r.nb)) && r.bvm[cyc % 8];
            drive_batch(r, bi);
            if (r.poke && cyc == 2) begin
                // R9: stray command with different start, color and swap.
                line_go  = 1'b1;
                go_major = ~r.smaj; go_minor = ~r.smin; go_color = ~r.col; go_swap = ~r.swap;
            end else begin
                line_go = 1'b0;
            end
            #1;
            if (hold_v)
                chk(pix_valid && pix_x == hx && pix_y == hy && pix_color == hc,
                    "R7 stall hold", {pix_x, pix_y}, {hx, hy});
            chk(!(pix_valid && batch_ready), "R11 exclusive", batch_ready, 0);
            if (batch_ready && k == 0) chk(1'b0, "R3 early batch request", k, 1);
            if (pix_valid && pix_ready) begin
                logic [CW-1:0] emaj, emin, ex, ey;
                emaj = r.smaj + CW'(k);
                emin = r.smin + CW'(k) * r.step;
                ex = r.swap ? emin : emaj;
                ey = r.swap ? emaj : emin;
                // R2 for k==0, R4/R8 ordering and mapping, R9 unchanged by stray command.
                chk(pix_x == ex && pix_y == ey,
                    (k == 0) ? "R2 start point" : "R4 R8 R9 entry", {pix_x, pix_y}, {ex, ey});
                chk(pix_color == r.col, "R10 color", pix_color, r.col);
                k++;
            end
            hold_v = pix_valid && !pix_ready;
            hx = pix_x; hy = pix_y; hc = pix_color;
            if (batch_ready && batch_valid) bi++;
            cyc++;
            @(negedge clk);
        end
        line_go = 1'b0;
        pix_ready = 1'b1;
        batch_valid = 1'b1;
        batch_end = '1;
        #1;
        chk(k == total, "R5 line length", k, total);
        chk(line_done && !pix_valid && !batch_ready, "R5 done pulse", line_done, 1);
        chk(bi == int'(r.nb), "R6 batches taken", bi, r.nb);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            chk(!pix_valid && !batch_ready && !line_done, "R5 idle after line",
                {pix_valid, batch_ready, line_done}, 0);
        end
        batch_valid = 1'b0;
        if (ri < 0) $display("unused");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; line_go = 1'b0; go_major = '0; go_minor = '0; go_color = '0;
        go_swap = 1'b0; batch_valid = 1'b0; batch_major = '0; batch_minor = '0;
        batch_end = '0; pix_ready = 1'b0;
        // R1: outputs quiet during reset, even with a command present.
        line_go = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!pix_valid && !batch_ready && !line_done, "R1 in reset",
            {pix_valid, batch_ready, line_done}, 0);
        line_go = 1'b0;
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!pix_valid && !batch_ready && !line_done, "R1 after reset",
            {pix_valid, batch_ready, line_done}, 0);

        for (int ri = 0; ri < 6; ri++) run_row(TBL[ri], ri);

        // R6 directed: with no batch offered the block waits with its request up.
        @(negedge clk);
        go_major = 12'd5; go_minor = 12'd6; go_color = 8'h77; go_swap = 1'b0;
        line_go = 1'b1; pix_ready = 1'b1;
        @(negedge clk); line_go = 1'b0;
        #1; chk(pix_valid && pix_x == 12'd5 && pix_y == 12'd6, "R2 start directed", pix_x, 5);
        repeat (4) begin
            @(negedge clk); #1;
            chk(batch_ready && !pix_valid, "R3 waiting for batch", batch_ready, 1);
        end
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk(!pix_valid && !batch_ready, "R1 reset mid-line", {pix_valid, batch_ready}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule